// File: doc/BRIEF.md
# Aperture Page-Table Address Translator

This block sits on a bus address path and remaps any address that lands inside a programmable window, the aperture, onto a 40-bit physical address. Each 4 KiB page of the window has a 32-bit entry in a table in memory. The table's base is held in a register. On a lookup that falls inside the window, the block works out which entry it needs and reads it over a request/response memory port. It then unpacks the physical page from the entry and appends the untouched byte offset. Addresses outside the window, and all addresses while translation is off, come back unchanged.

A small direct-mapped cache keeps recently fetched entries, so a repeated page needs no memory read. Software that rewrites the table must start a flush. A flush throws away every cached entry. Its command bit reads back as one until the work is done, so software polls it until it reads zero. While a flush is pending, the block stalls new lookups.

The register file has four 32-bit words, selected by `cfg_addr`:
- 0: control
- 1: aperture base
- 2: table base
- 3: flush

Lookups are accepted with a valid/ready pair. Each accepted lookup produces exactly one single-cycle response.

Top module: `gart_xlat`

## Requirements
- R1: When control bit 0 (enable) is 0, every accepted lookup responds in the next cycle with `rsp_paddr` equal to `req_addr`, `rsp_err` 0, and no memory read.
- R2: The window starts at aperture-base bits 14:0 shifted left by 25. Its size is 32 MiB shifted left by control bits 3:1. An address below the start, or at or above start plus size, passes through as in R1. The first and last byte of the window are translated.
- R3: A translated lookup that misses the cache raises `mem_req` with `mem_addr` = (table-base bits 31:4 shifted left by 8) + 4 × page index. The page index is (address − window start) >> 12. `mem_req` and `mem_addr` hold steady until `mem_rvalid`.
- R4: For an entry e with bit 0 set, the result is {e[11:4], e[31:12], address[11:0]}. The entry fields give physical bits 39:32 and 31:12, and the byte offset passes through unchanged.
- R5: An entry with bit 0 (valid) clear makes the response carry `rsp_err` = 1 and `rsp_paddr` = 0.
- R6: Fetched entries are cached in CACHE_ENTRIES slots. A slot is picked by the low bits of the page index and tagged with the full index. A repeat lookup that hits responds in the next cycle with no memory read, even if the table in memory has changed since. Two pages sharing a slot evict each other.
- R7: Writing 1 to flush bit 0 makes that bit read 1 at once, and `req_ready` stays 0 until the flush completes. The bit returns to 0 within a few cycles. After that, every page is fetched again from memory.
- R8: Register reads return control bits 5:0, aperture-base bits 14:0, table-base bits 31:4 and flush bit 0. All other bits read 0, and everything reads 0 after reset.
- R9: A miss response appears exactly one cycle after the cycle in which `mem_rvalid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | 40 | Bus address to translate |
| rsp_valid | output | 1 | Response valid, one cycle per lookup |
| rsp_err | output | 1 | Hit an entry with its valid bit clear |
| rsp_paddr | output | 40 | Translated or passed-through address |
| mem_req | output | 1 | Entry read request, held until answered |
| mem_addr | output | 40 | Byte address of the entry |
| mem_rvalid | input | 1 | Entry data valid |
| mem_rdata | input | 32 | Entry data |

## Verification
The bench aims at the window edges: one byte below the start, the first byte, the last byte and one past the end. A design with an off-by-one bound, or one that sized the window from the wrong field, would translate a pass-through address or the reverse. A stale-entry scenario changes the table behind a cached page. The old translation must come back until a flush, and the new one after it. A cache that ignored its tags, or a flush that did not clear the slots, would show up here. Two pages that share a slot check eviction. Random windows, table bases and memory latencies check the entry address arithmetic, the bit folding of the 40-bit page and the error response for an invalid entry.

// File: rtl/gart_xlat.sv
module gart_xlat #(
  parameter int CACHE_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [39:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [39:0] rsp_paddr,
  output logic        mem_req,
  output logic [39:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int CIW = $clog2(CACHE_ENTRIES);
  localparam int PIW = 20;

  logic [5:0]  ctl_q;
  logic [14:0] apb_q;
  logic [27:0] tbl_q;
  logic        flush_q;
  logic        fetch_q;
  logic [39:0] cur_addr_q;
  logic [PIW-1:0] cur_idx_q;
  logic [39:0] mem_addr_q;
  logic [CACHE_ENTRIES-1:0] cv_q;
  logic [PIW-1:0] ctag_q [CACHE_ENTRIES];
  logic [31:0]    cdat_q [CACHE_ENTRIES];

  logic [40:0] ap_lo, ap_size, ap_off;
  assign ap_lo   = {1'b0, apb_q, 25'd0};
  assign ap_size = 41'h2000000 << ctl_q[3:1];
  assign ap_off  = {1'b0, req_addr} - ap_lo;

  wire in_ap = ctl_q[0] && (ap_off < ap_size);
  wire [PIW-1:0] pidx = ap_off[31:12];
  wire [CIW-1:0] cslot = pidx[CIW-1:0];
  wire [CIW-1:0] fslot = cur_idx_q[CIW-1:0];
  wire c_hit = cv_q[cslot] && (ctag_q[cslot] == pidx);

  assign req_ready = !fetch_q && !flush_q;
  wire acc = req_valid && req_ready;
  wire fill = fetch_q && mem_rvalid;

  assign mem_req  = fetch_q;
  assign mem_addr = mem_addr_q;

  function automatic logic [39:0] unpack(input logic [31:0] e, input logic [11:0] off);
    return e[0] ? {e[11:4], e[31:12], off} : 40'd0;
  endfunction

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = {26'd0, ctl_q};
      2'd1:    cfg_rdata = {17'd0, apb_q};
      2'd2:    cfg_rdata = {tbl_q, 4'd0};
      default: cfg_rdata = {31'd0, flush_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0; apb_q <= '0; tbl_q <= '0; flush_q <= 1'b0;
      fetch_q <= 1'b0; cur_addr_q <= '0; cur_idx_q <= '0; mem_addr_q <= '0;
      cv_q <= '0; rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (flush_q && !fetch_q) begin
        cv_q    <= '0;
        flush_q <= 1'b0;
      end
      if (cfg_we) begin
        case (cfg_addr)
          2'd0:    ctl_q <= cfg_wdata[5:0];
          2'd1:    apb_q <= cfg_wdata[14:0];
          2'd2:    tbl_q <= cfg_wdata[31:4];
          default: if (cfg_wdata[0]) flush_q <= 1'b1;
        endcase
      end
      if (acc) begin
        cur_addr_q <= req_addr;
        cur_idx_q  <= pidx;
        if (!in_ap) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_paddr <= req_addr;
        end else if (c_hit) begin
          rsp_valid <= 1'b1;
          rsp_err   <= !cdat_q[cslot][0];
          rsp_paddr <= unpack(cdat_q[cslot], req_addr[11:0]);
        end else begin
          fetch_q    <= 1'b1;
          mem_addr_q <= {tbl_q, 12'd0} + {18'd0, pidx, 2'd0};
        end
      end
      if (fill) begin
        fetch_q     <= 1'b0;
        cv_q[fslot] <= 1'b1;
        rsp_valid   <= 1'b1;
        rsp_err     <= !mem_rdata[0];
        rsp_paddr   <= unpack(mem_rdata, cur_addr_q[11:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      ctag_q[fslot] <= cur_idx_q;
      cdat_q[fslot] <= mem_rdata;
    end
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_ap) |=> (rsp_valid && !rsp_err && rsp_paddr == $past(req_addr))); // R1
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R3
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_paddr[11:0] == cur_addr_q[11:0])); // R4
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_paddr == 40'd0)); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_q) |-> (cv_q == '0)); // R7
  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid) |=> rsp_valid); // R9
endmodule

// File: tb/gart_xlat_tb.sv
`timescale 1ns/1ps
module gart_xlat_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0; logic [31:0] cfg_rdata;
  logic req_valid = 0, req_ready; logic [39:0] req_addr = 0;
  logic rsp_valid, rsp_err; logic [39:0] rsp_paddr;
  logic mem_req; logic [39:0] mem_addr; logic mem_rvalid = 0; logic [31:0] mem_rdata = 0;

  always #2.5 clk = ~clk;

  gart_xlat u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  int total = 0, fails = 0;
  bit done = 0;
  logic [5:0] m_ctl = 0; logic [14:0] m_base = 0; logic [31:0] m_tbl = 0;
  logic [31:0] salt = 32'h1357_9bdf;
  int ovr = 0, mem_lat = 1, mcnt = 0, fetch_cnt = 0;
  logic [39:0] last_fa = 0;

  function automatic logic [31:0] ent(input logic [39:0] fa);
    logic [31:0] e;
    e = (fa[31:0] ^ {fa[39:32], 24'd0}) * 32'h9E3779B1 + salt;
    if (ovr == 1) e[0] = 1'b1;
    if (ovr == 2) e[0] = 1'b0;
    return e;
  endfunction

  function automatic void model(input logic [39:0] a, output bit tr, output logic [39:0] fa,
                                output logic [39:0] pa, output bit er);
    logic [40:0] lo, sz, off; logic [31:0] e;
    lo = {1'b0, m_base, 25'd0};
    sz = 41'd33554432 << m_ctl[3:1];
    off = {1'b0, a} - lo;
    tr = m_ctl[0] && (off < sz);
    fa = {m_tbl[31:4], 12'd0} + {18'd0, off[31:12], 2'd0};
    e = ent(fa);
    if (!tr) begin pa = a; er = 0; end
    else if (!e[0]) begin pa = 40'd0; er = 1; end
    else begin pa = {e[11:4], e[31:12], a[11:0]}; er = 0; end
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mem_rvalid) mem_rvalid = 0;
      else if (mem_req) begin
        mcnt++;
        if (mcnt >= mem_lat) begin
          mcnt = 0; fetch_cnt++; last_fa = mem_addr;
          mem_rdata = ent(mem_addr); mem_rvalid = 1;
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (a)
      2'd0: m_ctl = d[5:0];
      2'd1: m_base = d[14:0];
      2'd2: m_tbl = {d[31:4], 4'd0};
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic do_flush();
    int n;
    wr(2'd3, 32'd1);
    cfg_addr = 2'd3; #1;
    check(cfg_rdata == 32'd1, "R7 flush bit reads 1", cfg_rdata, 1);
    check(req_ready == 1'b0, "R7 ready low during flush", req_ready, 0);
    n = 0;
    while (cfg_rdata[0] && n < 20) begin @(negedge clk); #1; n++; end
    check(cfg_rdata == 32'd0, "R7 flush completes", cfg_rdata, 0);
  endtask

  task automatic lookup(input logic [39:0] a, output logic [39:0] pa, output bit er,
                        output int nf, output int lat);
    int f0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a; f0 = fetch_cnt;
    @(negedge clk);
    req_valid = 0; lat = 1;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    pa = rsp_paddr; er = rsp_err; nf = fetch_cnt - f0;
  endtask

  task automatic full_check(input logic [39:0] a, input string tag);
    bit tr, er, eer; logic [39:0] fa, pa, epa; int nf, lat;
    model(a, tr, fa, epa, eer);
    lookup(a, pa, er, nf, lat);
    check(pa == epa && er == eer, tag, {23'd0, er, pa}, {23'd0, eer, epa});
    if (!tr) check(nf == 0 && lat == 1, "R1 pass-through one cycle, no fetch", lat, 1);
    else if (nf != 0) check(last_fa == fa, "R3 entry address", last_fa, fa);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic [39:0] a, pa, pa_old, base; bit er, tr; logic [39:0] fa, epa; int nf, lat;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!rsp_valid && !mem_req && req_ready, "R8 reset outputs", {rsp_valid, mem_req, req_ready}, 3'b001);
    for (int r = 0; r < 4; r++) begin
      rd(r[1:0], d);
      check(d == 0, "R8 reset register value", d, 0);
    end
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); check(d == 32'h3F, "R8 control mask", d, 32'h3F);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check(d == 32'h7FFF, "R8 base mask", d, 32'h7FFF);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); check(d == 32'hFFFF_FFF0, "R8 table mask", d, 32'hFFFF_FFF0);

    // R1: disabled
    wr(2'd0, 32'h0E); wr(2'd1, 32'h0); wr(2'd2, 32'h0);
    for (int i = 0; i < 4; i++) full_check({$urandom, $urandom} & 40'h01_FFFF_FFFF, "R1 disabled passthrough");

    // R2 window edges, order 1 = 64 MiB
    wr(2'd0, 32'h03); wr(2'd1, 32'h12); wr(2'd2, 32'h0ABC_D000);
    do_flush();
    base = {15'h12, 25'd0};
    ovr = 1;
    full_check(base - 1, "R2 below window");
    full_check(base, "R2 first byte");
    full_check(base + 40'h3FF_FFFF, "R2 last byte");
    full_check(base + 40'h400_0000, "R2 one past end");

    // R4, R6, R9: miss then hit
    mem_lat = 3;
    a = base + 40'h5123;
    do_flush();
    model(a, tr, fa, epa, er);
    lookup(a, pa, er, nf, lat);
    check(nf == 1 && pa == epa, "R4 translated miss", pa, epa);
    check(lat == mem_lat + 1, "R9 miss latency", lat, mem_lat + 1);
    pa_old = pa;
    lookup(a + 40'h10, pa, er, nf, lat);
    check(nf == 0 && lat == 1, "R6 hit without fetch", {nf[7:0], lat[7:0]}, 16'h0001);
    check(pa == {pa_old[39:12], 12'h133}, "R4 offset kept on hit", pa, {pa_old[39:12], 12'h133});
    salt = salt + 32'h1000;
    lookup(a, pa, er, nf, lat);
    check(nf == 0 && pa == pa_old, "R6 stale entry kept until flush", pa, pa_old);
    do_flush();
    model(a, tr, fa, epa, er);
    lookup(a, pa, er, nf, lat);
    check(nf == 1 && pa == epa, "R7 refetch after flush", pa, epa);

    // R6 slot conflict: pages p and p+4 share a slot
    lookup(a + 40'h4000, pa, er, nf, lat);
    check(nf == 1, "R6 conflicting page misses", nf, 1);
    lookup(a, pa, er, nf, lat);
    check(nf == 1, "R6 evicted page refetched", nf, 1);

    // R5 invalid entry
    ovr = 2;
    do_flush();
    lookup(a, pa, er, nf, lat);
    check(er == 1 && pa == 0, "R5 invalid entry error", {er, pa}, {1'b1, 40'd0});
    lookup(a, pa, er, nf, lat);
    check(er == 1 && pa == 0 && nf == 0, "R5 cached invalid entry", {er, pa}, {1'b1, 40'd0});
    ovr = 0;

    // random configurations
    for (int c = 0; c < 10; c++) begin
      logic [40:0] sz;
      mem_lat = 1 + ($urandom % 4);
      wr(2'd0, {28'd0, ($urandom % 4 == 0) ? 1'b0 : 1'b0, 2'($urandom % 4), 1'b1} | (($urandom % 5 == 0) ? 32'd0 : 32'd0));
      if (c == 9) wr(2'd0, 32'h4);
      wr(2'd1, $urandom & 32'h7FFF);
      wr(2'd2, $urandom);
      do_flush();
      sz = 41'd33554432 << m_ctl[3:1];
      base = {m_base, 25'd0};
      a = base;
      for (int i = 0; i < 30; i++) begin
        case ($urandom % 5)
          0: a = base - 1 - 40'($urandom % 8192);
          1: a = base + sz[39:0] + 40'($urandom % 8192);
          2: a = {$urandom, $urandom};
          3: ;
          default: a = base + (40'($urandom) % sz[39:0]);
        endcase
        full_check(a, "R4/R5 random lookup");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule